// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a small two-bit-per-pixel cursor over a 24-bit pixel stream. The display pipeline feeds it the current horizontal count (in T-cycles), the current line count (in full lines), a pixel-valid strobe that marks active display, and the incoming pixel. Each output pixel is either the incoming pixel or one of three programmed cursor colours. The output is registered, so it appears one clock after its input.

Software programs the block through a 32-bit register write port. Bits 31:24 of each word carry the register address, bits 23:12 carry the vertical value and bits 11:0 carry the horizontal value. The cursor map holds 16 rows of 16 two-bit codes. It is loaded in-band. A write to the control address sets the position and switches a small controller from state `ST_DECODE` to state `ST_MAPLOAD`. In `ST_MAPLOAD` the next sixteen words are stored as map rows, whatever their top byte holds. The write of row 15 returns the controller to `ST_DECODE`. The controller has only these two transitions: decode-to-load on a control write, and load-to-decode on the sixteenth row.

An external general-control input supplies two flags. One enables the cursor. The other selects double size, in which every map code covers a 2x2 block of pixels.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the controller is in `ST_DECODE`, the map holds all zeros, the colours and position are zero, `pix_out` is 0 and `pix_out_valid` is 0.
- R2: A register word uses bits 31:24 as the address, bits 23:12 as the vertical position in lines and bits 11:0 as the horizontal position in T-cycles. Colour registers take their value from bits 23:0.
- R3: A write to address 0x5B while decoding changes only the cursor position and leaves the map untouched.
- R4: A write to address 0x5A while decoding sets the position and enters `ST_MAPLOAD`. The next 16 words are stored as rows 0 to 15 in order, with no address decoding, so colours and position do not change. The 17th word is decoded normally.
- R5: In a row word, bits 1:0 hold the code of the leftmost cursor pixel, and pixel k uses bits 2k+1:2k.
- R6: Addresses 0x57, 0x58 and 0x59 hold cursor colours 1, 2 and 3. Map codes 1, 2 and 3 select them.
- R7: Map code 0 is transparent: the incoming pixel passes through.
- R8: In normal size the cursor covers horizontal counts from H to H+15 and lines from V to V+15, where H and V are the programmed position. Pixels outside this window pass through.
- R9: With double size set, the cursor covers H to H+31 and V to V+31. Map column (count-H)/2 and map row (line-V)/2 are used.
- R10: A cursor colour replaces the pixel only when the cursor enable and `pix_valid` are both high. `pix_out` and `pix_out_valid` follow their inputs with one clock of latency.
- R11: While decoding, a write to any other address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register word strobe |
| reg_wdata | input | 32 | Register word: address, vertical value, horizontal value |
| cur_enable | input | 1 | Cursor enable flag from general control |
| cur_double | input | 1 | Double-size flag from general control |
| tcycle_cnt | input | 12 | Current horizontal position in T-cycles |
| line_cnt | input | 12 | Current line |
| pix_valid | input | 1 | Active-display pixel strobe |
| pix_in | input | 24 | Incoming pixel |
| pix_out | output | 24 | Registered output pixel |
| pix_out_valid | output | 1 | Registered pixel strobe |

## Verification
The bound assertions check every cycle that the output strobe tracks its input, that a disabled cursor or a pixel left of the cursor passes through, and that the load controller is entered and left at exactly the right words. They also check that colours hold still during a load and that foreign addresses change nothing. The order of bit pairs within a row, the replication in double size, the exact window edges and the decoding of the seventeenth word show only in the bench's scenarios. In those scenarios a reference model scans the cursor borders and compares every output pixel.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    parameter int ADDR_W  = 8;
    parameter int COORD_W = 12;
    parameter int PIX_W   = 24;
    parameter int MAP_DIM = 16;
    parameter int CODE_W  = 2;
    parameter int N_COLOR = 3;

    localparam int REG_W   = ADDR_W + 2 * COORD_W;
    localparam int ROW_W   = MAP_DIM * CODE_W;
    localparam int IDX_W   = $clog2(MAP_DIM);

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h5A;
    localparam logic [ADDR_W-1:0] A_POS    = 8'h5B;
    localparam logic [ADDR_W-1:0] A_COLOR1 = 8'h57;

    typedef enum logic [0:0] {
        ST_DECODE  = 1'b0,
        ST_MAPLOAD = 1'b1
    } load_state_e;

    typedef struct packed {
        logic [COORD_W-1:0] v;
        logic [COORD_W-1:0] h;
    } cur_pos_t;
endpackage

// File: rtl/cursor_regif.sv
module cursor_regif
    import cursor_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [REG_W-1:0]              reg_wdata,
    output cur_pos_t                      pos_q,
    output logic [N_COLOR-1:0][PIX_W-1:0] colors_q,
    output logic                          row_we,
    output logic [IDX_W-1:0]              row_idx,
    output logic [ROW_W-1:0]              row_data,
    output logic                          load_busy
);
    load_state_e          state_q, state_d;
    logic [IDX_W-1:0]     cnt_q;
    logic [ADDR_W-1:0]    addr;
    logic                 dec_ctrl, dec_pos;
    logic [N_COLOR-1:0]   dec_color;

    assign addr = reg_wdata[REG_W-1 -: ADDR_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DECODE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DECODE:  if (reg_wr && addr == A_CTRL) state_d = ST_MAPLOAD;
            ST_MAPLOAD: if (reg_wr && cnt_q == IDX_W'(MAP_DIM - 1)) state_d = ST_DECODE;
            default:    state_d = ST_DECODE;
        endcase
    end

    // output decode
    always_comb begin
        dec_ctrl  = 1'b0;
        dec_pos   = 1'b0;
        dec_color = '0;
        row_we    = 1'b0;
        unique case (state_q)
            ST_DECODE: begin
                dec_ctrl = reg_wr && addr == A_CTRL;
                dec_pos  = reg_wr && addr == A_POS;
                for (int i = 0; i < N_COLOR; i++)
                    dec_color[i] = reg_wr && addr == A_COLOR1 + ADDR_W'(i);
            end
            ST_MAPLOAD: row_we = reg_wr;
            default: ;
        endcase
    end

    assign row_idx   = cnt_q;
    assign row_data  = reg_wdata[ROW_W-1:0];
    assign load_busy = state_q == ST_MAPLOAD;

    // row counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (dec_ctrl) cnt_q <= '0;
        else if (row_we)   cnt_q <= cnt_q + 1'b1;
    end

    // position register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pos_q <= '0;
        else if (dec_ctrl || dec_pos) pos_q <= reg_wdata[2*COORD_W-1:0];
    end

    // colour registers
    for (genvar g = 0; g < N_COLOR; g++) begin : g_color
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            colors_q[g] <= '0;
            else if (dec_color[g]) colors_q[g] <= reg_wdata[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/cursor_map.sv
module cursor_map
    import cursor_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ROW_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_row,
    input  logic [IDX_W-1:0] rd_col,
    output logic [CODE_W-1:0] rd_code
);
    logic [MAP_DIM-1:0][ROW_W-1:0] rows_q;
    logic [ROW_W-1:0]              sel_row;

    for (genvar r = 0; r < MAP_DIM; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         rows_q[r] <= '0;
            else if (we && wr_idx == IDX_W'(r)) rows_q[r] <= wr_data;
        end
    end

    assign sel_row = rows_q[rd_row];
    assign rd_code = sel_row[rd_col*CODE_W +: CODE_W];
endmodule

// File: rtl/cursor_window.sv
module cursor_window
    import cursor_pkg::*;
(
    input  cur_pos_t           pos,
    input  logic [COORD_W-1:0] tcycle,
    input  logic [COORD_W-1:0] line,
    input  logic               dbl,
    output logic               hit,
    output logic [IDX_W-1:0]   col,
    output logic [IDX_W-1:0]   row
);
    localparam logic [COORD_W-1:0] SPAN1 = COORD_W'(MAP_DIM);
    localparam logic [COORD_W-1:0] SPAN2 = COORD_W'(2 * MAP_DIM);

    logic [COORD_W-1:0] dx, dy, span;
    logic               in_h, in_v;

    assign dx   = tcycle - pos.h;
    assign dy   = line - pos.v;
    assign span = dbl ? SPAN2 : SPAN1;
    assign in_h = (tcycle >= pos.h) && (dx < span);
    assign in_v = (line >= pos.v) && (dy < span);
    assign hit  = in_h && in_v;
    assign col  = dbl ? dx[IDX_W:1] : dx[IDX_W-1:0];
    assign row  = dbl ? dy[IDX_W:1] : dy[IDX_W-1:0];
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    input  logic               cur_enable,
    input  logic               cur_double,
    input  logic [11:0]        tcycle_cnt,
    input  logic [11:0]        line_cnt,
    input  logic               pix_valid,
    input  logic [23:0]        pix_in,
    output logic [23:0]        pix_out,
    output logic               pix_out_valid
);
    cur_pos_t                      pos_q;
    logic [N_COLOR-1:0][PIX_W-1:0] colors_q;
    logic                          row_we, load_busy, hit;
    logic [IDX_W-1:0]              row_idx, col, row;
    logic [ROW_W-1:0]              row_data;
    logic [CODE_W-1:0]             code;
    logic [PIX_W-1:0]              pix_sel;

    cursor_regif u_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .pos_q(pos_q), .colors_q(colors_q), .row_we(row_we),
        .row_idx(row_idx), .row_data(row_data), .load_busy(load_busy)
    );

    cursor_window u_win (
        .pos(pos_q), .tcycle(tcycle_cnt), .line(line_cnt), .dbl(cur_double),
        .hit(hit), .col(col), .row(row)
    );

    cursor_map u_map (
        .clk(clk), .rst_n(rst_n), .we(row_we), .wr_idx(row_idx),
        .wr_data(row_data), .rd_row(row), .rd_col(col), .rd_code(code)
    );

    always_comb begin
        pix_sel = pix_in;
        if (cur_enable && pix_valid && hit && code != '0)
            pix_sel = colors_q[code - 1'b1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_out       <= '0;
            pix_out_valid <= 1'b0;
        end else begin
            pix_out       <= pix_sel;
            pix_out_valid <= pix_valid;
        end
    end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
    import cursor_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [31:0]                   reg_wdata,
    input logic                          cur_enable,
    input logic [11:0]                   tcycle_cnt,
    input logic                          pix_valid,
    input logic [23:0]                   pix_in,
    input logic [23:0]                   pix_out,
    input logic                          pix_out_valid,
    input logic                          load_busy,
    input logic [IDX_W-1:0]              row_idx,
    input cur_pos_t                      pos_q,
    input logic [N_COLOR-1:0][PIX_W-1:0] colors_q
);
    logic [7:0] waddr;
    logic       foreign;
    assign waddr   = reg_wdata[31:24];
    assign foreign = waddr != A_CTRL && waddr != A_POS && waddr != 8'h57
                     && waddr != 8'h58 && waddr != 8'h59;

    assert_valid_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> pix_out_valid);
    assert_valid_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !pix_out_valid);
    assert_disabled_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cur_enable) |=> pix_out == $past(pix_in));
    assert_left_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && tcycle_cnt < pos_q.h) |=> pix_out == $past(pix_in));
    assert_load_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_busy && reg_wr && waddr == A_CTRL) |=> (load_busy && row_idx == '0));
    assert_load_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_busy && reg_wr && row_idx == IDX_W'(MAP_DIM - 1)) |=> !load_busy);
    assert_colour_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |=> $stable(colors_q));
    assert_pos_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_busy && reg_wr && waddr == A_POS) |=>
            (!load_busy && pos_q == $past(reg_wdata[23:0])));
    assert_foreign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_busy && reg_wr && foreign) |=>
            ($stable(pos_q) && $stable(colors_q) && !load_busy));
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .cur_enable(cur_enable), .tcycle_cnt(tcycle_cnt), .pix_valid(pix_valid),
    .pix_in(pix_in), .pix_out(pix_out), .pix_out_valid(pix_out_valid),
    .load_busy(load_busy), .row_idx(row_idx), .pos_q(pos_q), .colors_q(colors_q)
);

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/100ps
module sim_cursor_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        cur_enable = 1'b0, cur_double = 1'b0;
    logic [11:0] tcycle_cnt = '0, line_cnt = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_in = '0;
    logic [23:0] pix_out;
    logic        pix_out_valid;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_row [16];
    logic [23:0] m_col [4];
    int          m_h = 0, m_v = 0, m_left = 0;
    logic [31:0] sb_q [$];   // {req tag, expected pixel}

    always #2.5 clk = ~clk;   // 200 MHz

    cursor_overlay u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .cur_enable(cur_enable), .cur_double(cur_double),
        .tcycle_cnt(tcycle_cnt), .line_cnt(line_cnt), .pix_valid(pix_valid),
        .pix_in(pix_in), .pix_out(pix_out), .pix_out_valid(pix_out_valid)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // register write driver with model update (R2, R3, R4, R6, R11)
    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        if (m_left > 0) begin
            m_row[16 - m_left] = w;
            m_left--;
        end else begin
            case (w[31:24])
                8'h5A: begin m_h = int'(w[11:0]); m_v = int'(w[23:12]); m_left = 16; end
                8'h5B: begin m_h = int'(w[11:0]); m_v = int'(w[23:12]); end
                8'h57: m_col[1] = w[23:0];
                8'h58: m_col[2] = w[23:0];
                8'h59: m_col[3] = w[23:0];
                default: ;
            endcase
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [23:0] exp_pix(input int t, input int l, input logic [23:0] p);
        int span, dx, dy, c, r;
        logic [1:0] code;
        span = cur_double ? 32 : 16;
        dx = t - m_h;
        dy = l - m_v;
        if (!cur_enable || dx < 0 || dy < 0 || dx >= span || dy >= span) return p;
        c = cur_double ? dx / 2 : dx;
        r = cur_double ? dy / 2 : dy;
        code = m_row[r][2*c +: 2];
        return (code == 2'd0) ? p : m_col[code];
    endfunction

    // pixel driver: pushes the expected result into the scoreboard
    task automatic px(input int t, input int l, input int req);
        logic [23:0] p;
        p = {t[11:0], l[11:0]} ^ 24'h5A5A5A;
        @(negedge clk);
        tcycle_cnt = t[11:0];
        line_cnt = l[11:0];
        pix_in = p;
        pix_valid = 1'b1;
        sb_q.push_back({8'(req), exp_pix(t, l, p)});
    endtask

    task automatic idle();
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic scan(input int req);
        int span;
        span = cur_double ? 32 : 16;
        for (int l = m_v - 1; l <= m_v + span; l++)
            for (int t = m_h - 1; t <= m_h + span; t++)
                px(t, l, req);
        idle();
    endtask

    // monitor: pops and compares
    always @(negedge clk) begin
        if (rst_n && pix_out_valid) begin
            if (sb_q.size() == 0) begin
                check(10, 32'h1, 32'h0);
            end else begin
                logic [31:0] item;
                item = sb_q.pop_front();
                check(int'(item[31:24]), {8'h0, pix_out}, {8'h0, item[23:0]});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_row[i] = '0;
        for (int i = 0; i < 4; i++) m_col[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(1, {8'h0, pix_out}, 32'h0);
        check(1, {31'h0, pix_out_valid}, 32'h0);
        // R1: map starts transparent, position zero
        cur_enable = 1'b1;
        scan(1);

        // R6: colours; R2 colour field in bits 23:0
        wr(32'h57_11_22_33);
        wr(32'h58_44_55_66);
        wr(32'h59_77_88_99);
        // R4/R5: control write at H=100 V=20, then 16 rows
        wr({8'h5A, 12'd20, 12'd100});
        for (int r = 0; r < 16; r++) begin
            logic [31:0] w;
            for (int k = 0; k < 16; k++) w[2*k +: 2] = 2'((k + r) % 4);
            if (r == 3) w = 32'h5A00_0001;   // R4: address-like word is a row
            if (r == 7) w = 32'h57AB_CDE6;   // R4: colour-like word is a row
            if (r == 9) w = 32'h0000_0009;   // R5: only pixels 0 and 1 set
            wr(w);
        end
        // R4: 17th word decoded normally
        wr(32'h57_CA_FE_01);
        scan(8);   // R8 window edges, R5 bit order, R7 transparency

        // R10: disabled cursor passes through
        cur_enable = 1'b0;
        scan(10);
        cur_enable = 1'b1;
        // R10: invalid pixel gives no output strobe
        @(negedge clk);
        tcycle_cnt = 12'd100; line_cnt = 12'd20; pix_valid = 1'b0;
        @(negedge clk);
        check(10, {31'h0, pix_out_valid}, 32'h0);

        // R3: move only
        wr({8'h5B, 12'd5, 12'd10});
        scan(3);

        // R11: foreign addresses change nothing
        wr(32'h10_FF_FF_FF);
        wr(32'h56_00_00_00);
        scan(11);

        // R9: double size
        cur_double = 1'b1;
        scan(9);
        cur_double = 1'b0;

        // R7: colour slot zero never used for code 0
        wr(32'h58_00_00_00);
        scan(7);

        repeat (4) @(negedge clk);
        check(10, sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule